// File: doc/BRIEF.md
# Polarity-Rotating Key Store

This block is a small secure store for cryptographic keys: 256 words of 32 bits, held in registers. Each stored bit sits in a pair of cells, a primary cell and a shadow cell. After every refresh tick the contents are rewritten in complemented form, without any help from the host. The shadow cells first take a same-state copy of the primary cells. The primary cells are then reloaded from the shadows, inverted. A one-bit polarity flag records whether the array currently holds true or inverted data. Host reads and writes are corrected by that flag, so the host always sees true data and no cell keeps a constant level for long.

The store is split into four banks of 64 words. Tamper logic can zero any subset of banks in a single cycle through a clear mask. A cleared bank reads back as zeros whatever the current polarity, and it stays zero through later rotations.

The host port is a valid/ready request channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. While a request waits, the host must hold it stable and keep `req_valid` asserted. `req_ready` drops only during the two refresh phase cycles. A read returns its data with a one-cycle `rsp_valid` pulse in the cycle after acceptance. The response channel takes no back-pressure, so the host must take the data in that cycle.

Top module: `nim_keystore`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every word reads back as zero.
- R2: A read accepted at a clock edge gives `rsp_valid` = 1 in the following cycle, with `rsp_data` equal to the last value written to that address.
- R3: When `refresh_tick` is sampled high while the store is idle, `req_ready` is 0 for exactly the two cycles after that edge. The copy phase comes first and the inverting phase second. A tick that arrives during those two cycles is ignored.
- R4: Stored data reads back true after any number of refresh rotations, odd or even.
- R5: A word written while the array holds inverted polarity reads back true, both before and after later rotations.
- R6: Address bits [7:6] select the bank and bits [5:0] select the word within it. Each of the 256 addresses holds an independent word.
- R7: Setting bit b of `clear_mask` for one cycle makes every word of bank b read as zero, whatever the polarity. Words in the other banks are unchanged.
- R8: When a clear of a bank and an accepted write to that bank fall on the same edge, the clear wins and the word reads zero.
- R9: A cleared bank keeps reading zero after later rotations, including when the clear is applied during the copy phase or during the inverting phase.
- R10: The polarity flag changes only at the end of the inverting phase, and it changes at every such end.
- R11: While `req_ready` is 0 a pending request has no effect: no write takes place and no response is produced. The request is carried out once `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be accepted this cycle (low during refresh phases) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address: bank in [7:6], word in [5:0] |
| req_wdata | input | 32 | Write data, true polarity |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_data | output | 32 | Read data, true polarity |
| refresh_tick | input | 1 | Starts one polarity rotation |
| clear_mask | input | 4 | One bit per bank; a high bit zeros that bank |

## Verification
The properties assume that the host keeps each request stable while it waits. They also assume that `rsp_valid` is driven only by accepted reads, with ticks able to arrive at any cycle. The bench drives every input on the falling edge. It holds a request until it sees `req_ready` high, and it deliberately places ticks and clears inside the copy and inverting phases to reach the collisions named in R3, R8 and R9. A write collides with a clear only in a cycle where the bench has already seen the store idle.

// File: rtl/nim_pkg.sv
package nim_pkg;
  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_COPY = 2'd1,
    RF_FLIP = 2'd2
  } rf_state_e;
endpackage

// File: rtl/nim_refresh_fsm.sv
module nim_refresh_fsm
  import nim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_copy,
  output logic phase_flip,
  output logic idle,
  output logic pol
);
  rf_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      pol     <= 1'b0;
    end else begin
      case (state_q)
        RF_IDLE: if (tick) state_q <= RF_COPY;
        RF_COPY: state_q <= RF_FLIP;
        RF_FLIP: begin
          state_q <= RF_IDLE;
          pol     <= ~pol;
        end
        default: state_q <= RF_IDLE;
      endcase
    end
  end

  assign phase_copy = (state_q == RF_COPY);
  assign phase_flip = (state_q == RF_FLIP);
  assign idle       = (state_q == RF_IDLE);
endmodule

// File: rtl/nim_bank.sv
module nim_bank #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          copy_en,
  input  logic          flip_en,
  input  logic          clr_en,
  input  logic [W-1:0]  clr_pat,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] prim_q   [WORDS];
  logic [W-1:0] shadow_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        prim_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (clr_en) begin
          prim_q[i]   <= clr_pat;
          shadow_q[i] <= clr_pat;
        end else begin
          if (copy_en) shadow_q[i] <= prim_q[i];
          if (flip_en) prim_q[i] <= ~shadow_q[i];
          else if (wr_en && idx == IW'(i)) prim_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_word = prim_q[idx];
endmodule

// File: rtl/nim_access.sv
module nim_access #(
  parameter int W     = 32,
  parameter int BANKS = 4,
  parameter int WORDS = 64,
  localparam int BW   = $clog2(BANKS),
  localparam int IW   = $clog2(WORDS),
  localparam int AW   = BW + IW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [W-1:0]              req_wdata,
  input  logic                      idle,
  input  logic                      pol,
  input  logic [BANKS-1:0][W-1:0]   rd_words,
  output logic [BANKS-1:0]          wr_en,
  output logic [IW-1:0]             idx,
  output logic [W-1:0]              wr_data,
  output logic                      rsp_valid,
  output logic [W-1:0]              rsp_data
);
  logic [BW-1:0] bank_sel;
  logic          accept;
  logic [W-1:0]  pol_mask;

  assign bank_sel = req_addr[IW +: BW];
  assign idx      = req_addr[IW-1:0];
  assign accept   = req_valid && idle;
  assign pol_mask = {W{pol}};
  assign wr_data  = req_wdata ^ pol_mask;

  for (genvar b = 0; b < BANKS; b++) begin : g_wen
    assign wr_en[b] = accept && req_write && (bank_sel == BW'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_data <= rd_words[bank_sel] ^ pol_mask;
    end
  end
endmodule

// File: rtl/nim_keystore.sv
module nim_keystore #(
  parameter int W          = 32,
  parameter int BANKS      = 4,
  parameter int BANK_WORDS = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [$clog2(BANKS*BANK_WORDS)-1:0]   req_addr,
  input  logic [W-1:0]                          req_wdata,
  output logic                                  rsp_valid,
  output logic [W-1:0]                          rsp_data,
  input  logic                                  refresh_tick,
  input  logic [BANKS-1:0]                      clear_mask
);
  localparam int IW = $clog2(BANK_WORDS);

  logic                    phase_copy, phase_flip, idle, pol;
  logic [BANKS-1:0]        wr_en;
  logic [IW-1:0]           idx;
  logic [W-1:0]            wr_data;
  logic [BANKS-1:0][W-1:0] rd_words;
  logic [W-1:0]            clr_pat;

  nim_refresh_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (refresh_tick),
    .phase_copy (phase_copy),
    .phase_flip (phase_flip),
    .idle       (idle),
    .pol        (pol)
  );

  nim_access #(.W(W), .BANKS(BANKS), .WORDS(BANK_WORDS)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .idle      (idle),
    .pol       (pol),
    .rd_words  (rd_words),
    .wr_en     (wr_en),
    .idx       (idx),
    .wr_data   (wr_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // zero in the polarity that will hold after this edge
  assign clr_pat   = {W{pol ^ phase_flip}};
  assign req_ready = idle;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    nim_bank #(.W(W), .WORDS(BANK_WORDS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .copy_en (phase_copy),
      .flip_en (phase_flip),
      .clr_en  (clear_mask[b]),
      .clr_pat (clr_pat),
      .wr_en   (wr_en[b]),
      .idx     (idx),
      .wr_data (wr_data),
      .rd_word (rd_words[b])
    );
  end
endmodule

// File: rtl/nim_keystore_chk.sv
module nim_keystore_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic refresh_tick,
  input logic rsp_valid,
  input logic phase_copy,
  input logic phase_flip,
  input logic pol
);
  // R3
  tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_tick && req_ready) |=> (!req_ready && phase_copy));

  // R3
  copy_then_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_copy |=> (phase_flip && !req_ready));

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  // R10
  pol_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol) |-> $past(phase_flip));

  // R10
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_flip |=> (pol != $past(pol)));
endmodule

bind nim_keystore nim_keystore_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .refresh_tick (refresh_tick),
  .rsp_valid    (rsp_valid),
  .phase_copy   (phase_copy),
  .phase_flip   (phase_flip),
  .pol          (pol)
);

// File: tb/tb_nim_keystore.sv
`timescale 1ns/1ps
module tb_nim_keystore;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        refresh_tick = 1'b0;
  logic [3:0]  clear_mask = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  nim_keystore dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .refresh_tick(refresh_tick), .clear_mask(clear_mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // host access; any stall cycle must show no response (R11)
  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin
      check("R11 no response while stalled", {31'b0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    q = rsp_data;
    if (!wr) check("R2 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, d, q);
    model[a] = d;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    logic [31:0] q;
    access(1'b0, a, '0, q);
    check(req, q, model[a]);
  endtask

  task automatic verify_all(input string req);
    for (int a = 0; a < 256; a++) rd_check(req, 8'(a));
  endtask

  // R3: ready low for exactly two cycles
  task automatic refresh();
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
    check("R3 copy phase stalls", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check("R3 flip phase stalls", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check("R3 idle after two phases", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic clear_banks(input logic [3:0] m);
    @(negedge clk);
    clear_mask = m;
    @(negedge clk);
    clear_mask = '0;
    for (int a = 0; a < 256; a++) if (m[a >> 6]) model[a] = '0;
  endtask

  task automatic t_reset();
    check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    check("R1 no response after reset", {31'b0, rsp_valid}, 32'd0);
    verify_all("R1 zero after reset");
  endtask

  task automatic t_fill();
    for (int a = 0; a < 256; a++)
      wr_word(8'(a), {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'hC3 ^ 8'(a >> 2)});
    verify_all("R6 R2 independent words");
  endtask

  task automatic t_rotate();
    refresh();
    verify_all("R4 odd rotation");
    wr_word(8'h07, 32'hDEAD_BEEF);
    wr_word(8'hC0, 32'h0000_0001);
    rd_check("R5 write at inverted polarity", 8'h07);
    rd_check("R5 write at inverted polarity", 8'hC0);
    refresh();
    verify_all("R4 R5 even rotation");
  endtask

  task automatic t_tick_ignored();
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);   // copy phase; tick held high
    @(negedge clk);   // flip phase
    refresh_tick = 1'b0;
    @(negedge clk);
    check("R3 idle after sequence", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    check("R3 tick during phases ignored", {31'b0, req_ready}, 32'd1);
    verify_all("R4 after third rotation");
  endtask

  task automatic t_stall();
    // tick then immediately pending write and read
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
    wr_word(8'h45, 32'h1234_5678);
    rd_check("R11 stalled write applied later", 8'h45);
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
    rd_check("R11 stalled read returns data", 8'h45);
  endtask

  task automatic t_clear();
    clear_banks(4'b0010);
    verify_all("R7 clear bank 1");
    refresh();
    clear_banks(4'b0100);
    verify_all("R7 clear bank 2 other polarity");
    refresh();
    verify_all("R9 cleared banks stay zero");
  endtask

  task automatic t_clear_vs_write();
    @(negedge clk);
    check("R8 precondition idle", {31'b0, req_ready}, 32'd1);
    clear_mask = 4'b0001;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h05; req_wdata = 32'hFFFF_0000;
    @(negedge clk);
    clear_mask = '0; req_valid = 1'b0; req_write = 1'b0;
    for (int a = 0; a < 64; a++) model[a] = '0;
    rd_check("R8 clear beats write", 8'h05);
    verify_all("R7 R8 other banks intact");
  endtask

  task automatic t_clear_in_phase();
    wr_word(8'hC1, 32'hA5A5_A5A5);
    wr_word(8'h11, 32'h5A5A_0F0F);
    // clear bank 3 during copy phase
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
    clear_mask = 4'b1000;
    @(negedge clk);
    clear_mask = '0;
    for (int a = 192; a < 256; a++) model[a] = '0;
    verify_all("R9 clear in copy phase");
    // clear bank 0 during flip phase
    @(negedge clk);
    refresh_tick = 1'b1;
    @(negedge clk);
    refresh_tick = 1'b0;
    @(negedge clk);
    clear_mask = 4'b0001;
    @(negedge clk);
    clear_mask = '0;
    for (int a = 0; a < 64; a++) model[a] = '0;
    verify_all("R9 clear in flip phase");
    refresh();
    verify_all("R9 zero after further rotation");
  endtask

  initial begin
    for (int a = 0; a < 256; a++) model[a] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_rotate();
    t_tick_ignored();
    t_stall();
    t_clear();
    t_clear_vs_write();
    t_clear_in_phase();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule